// File: doc/BRIEF.md
# Dual-VFO Decimal Tuning Counter

This block keeps the tuned frequency of a receiver front end as two separate banks of cascaded decimal digits, called VFO A and VFO B. Each bank holds six BCD digits that weigh 10 MHz, 1 MHz, 100 kHz, 10 kHz, 1 kHz and 100 Hz. A rotary tuning knob supplies a step pulse and a direction level. Each step pulse moves the selected bank up or down by one count of its least significant digit. A latched fast-tuning level makes each step move the 10 kHz digit instead, and it holds the two lowest digits at zero.

An external controller can also write a whole frequency. A clear strobe zeroes the selected bank and writes the data bus into the 10 MHz digit. Each later data-valid pulse then writes the next lower digit. Band-bottom presets use the same path, for example to put 8 or 5 on the 100 kHz digit. All control inputs may be asynchronous. The block synchronizes them and acts on rising edges, so one pulse gives exactly one step or one write.

Top module: `vfo_tuner`

## Requirements
- R1: After reset, both banks read zero, and `freq_bcd` is all zeros whichever bank is selected.
- R2: `freq_bcd` carries six BCD digits. Bits [3:0] hold the 100 Hz digit and bits [23:20] hold the 10 MHz digit. It shows bank A when `vfo_sel` is 0 and bank B when it is 1.
- R3: Each rising edge of `tune_clk` adds one to the selected bank's 100 Hz digit when `tune_up` is 1, or subtracts one when it is 0. A pulse held high for many cycles counts only once.
- R4: Counting is decimal. An increment from 9 gives 0 and carries into the next digit up. A decrement from 0 gives 9 and borrows from it.
- R5: The count wraps at the ends of its range. 999999 plus one step gives 000000, and 000000 minus one step gives 999999.
- R6: Steps and writes affect only the selected bank. The other bank keeps its value until it is selected again.
- R7: While `fast_mode` is 1, the selected bank's 1 kHz and 100 Hz digits are held at 0, and each step adds or subtracts one at the 10 kHz digit, carrying or borrowing upward.
- R8: A rising edge of `clr_strobe` zeroes every digit of the selected bank below 10 MHz and writes `load_data` into the 10 MHz digit.
- R9: After a clear, each rising edge of `load_valid` writes `load_data` into the next lower digit, from 1 MHz down to 100 Hz. Further writes are ignored until the next clear. Writes that arrive after reset and before the first clear are also ignored.
- R10: `load_data` carries weights 1, 2, 4 and 8 on bits 0 to 3. A written value above 9 is stored as 0. The 8 preset uses bit 3 only, and the 5 preset uses bits 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_clk | input | 1 | Knob step pulse; may be asynchronous |
| tune_up | input | 1 | Step direction: 1 counts up, 0 counts down |
| vfo_sel | input | 1 | Bank select: 0 selects A, 1 selects B |
| fast_mode | input | 1 | Latched fast-tuning level |
| clr_strobe | input | 1 | Clear strobe; also writes the 10 MHz digit |
| load_valid | input | 1 | Write pulse for the next lower digit |
| load_data | input | 4 | BCD write data, weights 1, 2, 4 and 8 |
| freq_bcd | output | 24 | Digits of the selected bank, 4 bits each |

## Verification
The bench builds the block with its default parameters: six digits, fast steps at digit index 2, and a two-stage synchronizer. With six digits, a single step from the written value 999999 or from zero reaches the wrap in both directions. A digit-by-digit write can reach the end of the pointer, so writes past the 100 Hz digit are exercised. With the fast index at 2, a fast step from 129955 clears the low digits and carries across two digits to 130000. The two-stage synchronizer keeps the input-to-output latency short, so each long-held pulse still settles well inside the wait the bench allows.

// File: rtl/vfo_pkg.sv
// Shared types and helpers for the dual-VFO tuning counter.
// Assumes four-bit BCD digits throughout.
package vfo_pkg;

    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    // Maps any non-decimal code onto zero so stored digits stay legal.
    function automatic bcd_t bcd_sanitize(input logic [BCD_W-1:0] raw);
        return (raw > 4'd9) ? 4'd0 : raw;
    endfunction

endpackage

// File: rtl/vfo_input_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bundled input is held steady for longer than STAGES cycles
// around the edges that matter; stages reset low synchronously.
module vfo_input_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/vfo_bcd_digit.sv
// One decimal digit with increment, decrement, zero and write controls.
// Priority: zero, then write, then increment, then decrement.
// Assumes the caller never raises inc_in and dec_in together.
module vfo_bcd_digit
    import vfo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_in,
    input  logic dec_in,
    input  logic zero_in,
    input  logic load_in,
    input  bcd_t load_val,
    output bcd_t digit_q,
    output logic carry_out,
    output logic borrow_out
);

    // Update the digit according to the control priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        digit_q <= '0;
        else if (zero_in)  digit_q <= '0;
        else if (load_in)  digit_q <= bcd_sanitize(load_val);
        else if (inc_in)   digit_q <= (digit_q == 4'd9) ? 4'd0 : digit_q + 4'd1;
        else if (dec_in)   digit_q <= (digit_q == 4'd0) ? 4'd9 : digit_q - 4'd1;
    end

    // Ripple a carry or a borrow to the next digit up.
    always_comb begin
        carry_out  = inc_in && (digit_q == 4'd9);
        borrow_out = dec_in && (digit_q == 4'd0);
    end

endmodule

// File: rtl/vfo_digit_bank.sv
// One VFO: a chain of NUM_DIGITS decimal digits, index 0 least significant.
// A normal step enters at digit 0. A fast step enters at FAST_IDX, and the
// digits below it are held at zero. A clear zeroes all digits except the top
// one, which takes clear_val. A write targets digit load_idx.
// Assumes 1 <= FAST_IDX < NUM_DIGITS-1 and at most one of step, clear and
// write active per cycle.
module vfo_digit_bank
    import vfo_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int FAST_IDX   = 2,
    localparam int IDX_W     = $clog2(NUM_DIGITS),
    localparam int FREQ_W    = NUM_DIGITS * BCD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              step_up,
    input  logic              fast_en,
    input  logic              clear_en,
    input  bcd_t              clear_val,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  bcd_t              load_val,
    output logic [FREQ_W-1:0] digits_q
);

    localparam int TOP = NUM_DIGITS - 1;

    logic [NUM_DIGITS-1:0] inc, dec, carry, borrow, zero_req, wr_en;
    bcd_t                  wr_val;
    logic                  up_norm, dn_norm, up_fast, dn_fast;

    // Split the step request into its normal and fast entry points.
    always_comb begin
        up_norm = step_en &&  step_up && !fast_en;
        dn_norm = step_en && !step_up && !fast_en;
        up_fast = step_en &&  step_up &&  fast_en;
        dn_fast = step_en && !step_up &&  fast_en;
        wr_val  = clear_en ? clear_val : load_val;
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        // Choose where this digit's increment and decrement come from.
        if (i == 0) begin : g_lsd
            assign inc[i] = up_norm;
            assign dec[i] = dn_norm;
        end else if (i == FAST_IDX) begin : g_fast
            assign inc[i] = carry[i-1]  || up_fast;
            assign dec[i] = borrow[i-1] || dn_fast;
        end else begin : g_chain
            assign inc[i] = carry[i-1];
            assign dec[i] = borrow[i-1];
        end

        // Zeroing comes from fast mode (low digits) or from a clear (below top).
        if (i < FAST_IDX) begin : g_low
            assign zero_req[i] = fast_en || clear_en;
        end else if (i == TOP) begin : g_top
            assign zero_req[i] = 1'b0;
        end else begin : g_mid
            assign zero_req[i] = clear_en;
        end

        // Writes reach the top digit on a clear and the indexed digit on a load.
        if (i == TOP) begin : g_wr_top
            assign wr_en[i] = clear_en || (load_en && (load_idx == IDX_W'(i)));
        end else begin : g_wr_other
            assign wr_en[i] = load_en && (load_idx == IDX_W'(i));
        end

        vfo_bcd_digit i_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_in     (inc[i]),
            .dec_in     (dec[i]),
            .zero_in    (zero_req[i]),
            .load_in    (wr_en[i]),
            .load_val   (wr_val),
            .digit_q    (digits_q[i*BCD_W +: BCD_W]),
            .carry_out  (carry[i]),
            .borrow_out (borrow[i])
        );
    end

endmodule

// File: rtl/vfo_tuner.sv
// Dual-VFO decimal tuning counter, the top level.
// Synchronizes all inputs, detects rising edges of the step, write and clear
// pulses, tracks the digit write pointer and routes events to the selected bank.
// Event priority within a cycle: clear, then write, then step.
// Assumes load_data, tune_up and vfo_sel are settled before their strobe rises.
module vfo_tuner
    import vfo_pkg::*;
#(
    parameter int NUM_DIGITS  = 6,
    parameter int FAST_IDX    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tune_clk,
    input  logic                        tune_up,
    input  logic                        vfo_sel,
    input  logic                        fast_mode,
    input  logic                        clr_strobe,
    input  logic                        load_valid,
    input  logic [3:0]                  load_data,
    output logic [NUM_DIGITS*4-1:0]     freq_bcd
);

    localparam int FREQ_W = NUM_DIGITS * BCD_W;
    localparam int PTR_W  = $clog2(NUM_DIGITS + 1);
    localparam int IDX_W  = $clog2(NUM_DIGITS);
    localparam int IN_W   = 6 + BCD_W;

    logic [IN_W-1:0]   sync_vec;
    logic              tclk_s, ldv_s, clr_s, up_s, sel_s, fast_s;
    bcd_t              data_s;
    logic [2:0]        pulse_q;
    logic              step_ev, load_ev, clr_ev;
    logic              step_ok, load_ok;
    logic [PTR_W-1:0]  load_ptr;
    logic [IDX_W-1:0]  load_idx;
    logic [FREQ_W-1:0] bank_q [2];

    vfo_input_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({tune_clk, load_valid, clr_strobe, tune_up, vfo_sel, fast_mode, load_data}),
        .sync_out (sync_vec)
    );

    assign {tclk_s, ldv_s, clr_s, up_s, sel_s, fast_s, data_s} = sync_vec;

    // Remember the previous synchronized pulse levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= {tclk_s, ldv_s, clr_s};
    end

    // Turn rising edges into events and resolve their priority.
    always_comb begin
        step_ev  = tclk_s && !pulse_q[2];
        load_ev  = ldv_s  && !pulse_q[1];
        clr_ev   = clr_s  && !pulse_q[0];
        load_ok  = load_ev && !clr_ev && (load_ptr < PTR_W'(NUM_DIGITS));
        step_ok  = step_ev && !clr_ev && !load_ev;
        load_idx = IDX_W'(NUM_DIGITS - 1) - IDX_W'(load_ptr);
    end

    // Track the write pointer: a clear re-arms it, and each accepted write advances it.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_ptr <= PTR_W'(NUM_DIGITS);
        else if (clr_ev)  load_ptr <= PTR_W'(1);
        else if (load_ok) load_ptr <= load_ptr + PTR_W'(1);
    end

    for (genvar b = 0; b < 2; b++) begin : g_vfo
        logic mine;
        assign mine = (sel_s == 1'(b));

        vfo_digit_bank #(
            .NUM_DIGITS (NUM_DIGITS),
            .FAST_IDX   (FAST_IDX)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_en   (step_ok && mine),
            .step_up   (up_s),
            .fast_en   (fast_s && mine),
            .clear_en  (clr_ev && mine),
            .clear_val (data_s),
            .load_en   (load_ok && mine),
            .load_idx  (load_idx),
            .load_val  (data_s),
            .digits_q  (bank_q[b])
        );
    end

    // Present the selected bank.
    assign freq_bcd = sel_s ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/vfo_tuner_chk.sv
// Property checker for vfo_tuner, attached through bind.
// Observes the output and the synchronized events that feed the banks.
module vfo_tuner_chk #(
    parameter int NUM_DIGITS = 6,
    parameter int FAST_IDX   = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_DIGITS*4-1:0]             freq_bcd,
    input logic                                step_ev,
    input logic                                up_s,
    input logic                                fast_s,
    input logic                                sel_s,
    input logic                                clr_ev,
    input logic                                load_ev,
    input logic [$clog2(NUM_DIGITS+1)-1:0]     load_ptr
);

    localparam int FREQ_W = NUM_DIGITS * 4;
    localparam int PTR_W  = $clog2(NUM_DIGITS + 1);

    // R4: every digit on the output stays a legal decimal code.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_bcd
        assert_bcd_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            freq_bcd[g*4 +: 4] <= 4'd9);
    end

    // R3: a lone normal up-step advances the 100 Hz digit by one, modulo ten.
    assert_step_up_lsd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_ev && up_s && !fast_s && !clr_ev && !load_ev) && (sel_s == $past(sel_s)))
        |-> (freq_bcd[3:0] == (($past(freq_bcd[3:0]) == 4'd9) ? 4'd0 : $past(freq_bcd[3:0]) + 4'd1)));

    // R3: with no event and no fast mode, the shown frequency holds.
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step_ev || clr_ev || load_ev || fast_s) && (sel_s == $past(sel_s)))
        |-> (freq_bcd == $past(freq_bcd)));

    // R7: fast mode held on the same bank keeps the low digits at zero.
    assert_fast_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_s && $past(fast_s) && (sel_s == $past(sel_s)))
        |-> (freq_bcd[FAST_IDX*4-1:0] == '0));

    // R8: after a clear, every digit below the top one reads zero.
    assert_clear_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_ev) && (sel_s == $past(sel_s)))
        |-> (freq_bcd[FREQ_W-5:0] == '0));

    // R9: the write pointer never runs past the last digit.
    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_ptr <= PTR_W'(NUM_DIGITS));

endmodule

bind vfo_tuner vfo_tuner_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .FAST_IDX   (FAST_IDX)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_bcd (freq_bcd),
    .step_ev  (step_ev),
    .up_s     (up_s),
    .fast_s   (fast_s),
    .sel_s    (sel_s),
    .clr_ev   (clr_ev),
    .load_ev  (load_ev),
    .load_ptr (load_ptr)
);

// File: tb/test_vfo_tuner.sv
// Scoreboard bench for vfo_tuner: driver tasks update a digit model and
// queue the expected frequency, and a monitor pops and compares.
module test_vfo_tuner;

    localparam int ND = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tune_clk = 1'b0, tune_up = 1'b0, vfo_sel = 1'b0, fast_mode = 1'b0;
    logic          clr_strobe = 1'b0, load_valid = 1'b0;
    logic [3:0]    load_data = 4'd0;
    logic [ND*4-1:0] freq_bcd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int md [2][ND];
    int mptr = ND;
    int msel = 0;
    bit mfast = 1'b0;

    logic [ND*4-1:0] exp_q [$];
    string           tag_q [$];

    always #4 clk = ~clk;

    vfo_tuner i_vfo_tuner (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_clk   (tune_clk),
        .tune_up    (tune_up),
        .vfo_sel    (vfo_sel),
        .fast_mode  (fast_mode),
        .clr_strobe (clr_strobe),
        .load_valid (load_valid),
        .load_data  (load_data),
        .freq_bcd   (freq_bcd)
    );

    function automatic logic [ND*4-1:0] model_bcd(input int b);
        logic [ND*4-1:0] v = '0;
        for (int i = 0; i < ND; i++) v[i*4 +: 4] = 4'(md[b][i]);
        return v;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_q.push_back(model_bcd(msel));
        tag_q.push_back(tag);
        wait_cyc(2);
    endtask

    task automatic tune(input bit up, input int hold);
        @(negedge clk);
        tune_up = up;
        wait_cyc(1);
        tune_clk = 1'b1;
        wait_cyc(hold);
        tune_clk = 1'b0;
        wait_cyc(5);
        begin
            int start = mfast ? 2 : 0;
            for (int i = start; i < ND; i++) begin
                if (up) begin
                    md[msel][i] = (md[msel][i] + 1) % 10;
                    if (md[msel][i] != 0) break;
                end else begin
                    md[msel][i] = (md[msel][i] + 9) % 10;
                    if (md[msel][i] != 9) break;
                end
            end
        end
    endtask

    task automatic clear_with(input logic [3:0] d);
        @(negedge clk);
        load_data = d;
        wait_cyc(1);
        clr_strobe = 1'b1;
        wait_cyc(4);
        clr_strobe = 1'b0;
        wait_cyc(5);
        for (int i = 0; i < ND - 1; i++) md[msel][i] = 0;
        md[msel][ND-1] = (d > 9) ? 0 : int'(d);
        mptr = 1;
    endtask

    task automatic load_with(input logic [3:0] d);
        @(negedge clk);
        load_data = d;
        wait_cyc(1);
        load_valid = 1'b1;
        wait_cyc(4);
        load_valid = 1'b0;
        wait_cyc(5);
        if (mptr < ND) begin
            md[msel][ND-1-mptr] = (d > 9) ? 0 : int'(d);
            mptr++;
        end
    endtask

    task automatic select_vfo(input int b);
        @(negedge clk);
        vfo_sel = 1'(b);
        msel = b;
        wait_cyc(5);
        if (mfast) begin md[msel][0] = 0; md[msel][1] = 0; end
    endtask

    task automatic set_fast(input bit f);
        @(negedge clk);
        fast_mode = f;
        mfast = f;
        wait_cyc(5);
        if (f) begin md[msel][0] = 0; md[msel][1] = 0; end
    endtask

    // Monitor: compare queued expectations against the output.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [ND*4-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (freq_bcd !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, freq_bcd, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int i = 0; i < ND; i++) md[b][i] = 0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        expect_now("R1 reset value");

        load_with(4'd5);                 expect_now("R9 write before any clear ignored");

        tune(1'b1, 2);
        tune(1'b1, 12);                  expect_now("R3 long pulse counts once");
        tune(1'b1, 3);                   expect_now("R3 up steps");
        tune(1'b0, 3);                   expect_now("R3 down step");
        tune(1'b0, 3); tune(1'b0, 3);
        tune(1'b0, 3);                   expect_now("R5 wrap below zero");
        tune(1'b1, 3);                   expect_now("R5 wrap above all nines");

        clear_with(4'd0);
        for (int k = 0; k < 4; k++) load_with(4'd0);
        load_with(4'd9);                 expect_now("R9 written 000009");
        tune(1'b1, 3);                   expect_now("R4 carry into 1 kHz");
        tune(1'b0, 3);                   expect_now("R4 borrow from 1 kHz");

        clear_with(4'd1);                expect_now("R8 clear writes top digit");
        load_with(4'd4); load_with(4'd2); load_with(4'd3);
        load_with(4'd4); load_with(4'd5); expect_now("R9 digits written top down");
        load_with(4'd7);                 expect_now("R9 write past last digit ignored");

        select_vfo(1);                   expect_now("R2 bank B shown");
        tune(1'b1, 3); tune(1'b1, 3);    expect_now("R6 bank B steps");
        select_vfo(0);                   expect_now("R6 bank A untouched");

        clear_with(4'd1);
        load_with(4'd2); load_with(4'd9); load_with(4'd9);
        load_with(4'd5); load_with(4'd5); expect_now("R9 written 129955");
        set_fast(1'b1);                  expect_now("R7 low digits cleared");
        tune(1'b1, 3);                   expect_now("R7 fast step carries");
        tune(1'b0, 3);                   expect_now("R7 fast step down");
        set_fast(1'b0);
        tune(1'b1, 3);                   expect_now("R3 normal step after fast");

        clear_with(4'd0);
        load_with(4'd1); load_with(4'b1000); expect_now("R10 preset eight");
        clear_with(4'd0);
        load_with(4'd3); load_with(4'b0101); expect_now("R10 preset five");
        load_with(4'hC);                 expect_now("R10 non-decimal write stored as zero");
        clear_with(4'hB);                expect_now("R10 non-decimal clear data stored as zero");

        wait_cyc(4);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule